// File: doc/BRIEF.md
# Privilege-Aware Flag-Restore Write Mask

This block holds a 32-bit processor status word and decides how a flags value popped from the stack updates it. Each update is qualified by a one-cycle valid strobe. With the strobe come the popped value, the current privilege level (0 to 3), a virtual-8086 mode indication, the operand size (16 or 32 bits) and an enable for the virtual-mode extensions. The block builds a per-bit write mask from these inputs and from the I/O privilege field held in the status word. The bits the mask permits take the popped value and the other bits keep their old value. The new word is stored on the next clock edge.

Outside virtual-8086 mode, a restore with too little privilege never faults: the protected bits stay as they were and the permitted bits still update. In virtual-8086 mode, a restore that is not allowed raises a general-protection fault pulse instead, and the status word is not written. When the extensions are enabled, a 16-bit restore with a low I/O privilege field writes the popped interrupt bit into the virtual interrupt flag.

Bit map used throughout: CF=0, bit 1 constant 1, PF=2, AF=4, ZF=6, SF=7, TF=8, IF=9, DF=10, OF=11, IOPL=13:12, NT=14, RF=16, VM=17, AC=18, VIF=19, VIP=20, ID=21. All other bits are reserved and read 0.

Top module: `flag_restore_unit`

## Requirements
- R1: After reset the status word reads 32'h0000_0002. At all times bit 1 reads 1 and the reserved bits (3, 5, 15, 31:22) read 0.
- R2: At privilege level 0 outside virtual-8086 mode, every defined bit may take the popped value, including IOPL, IF and RF. VM, VIP and VIF keep their old values, and no fault is raised.
- R3: At privilege level 1 to 3 outside virtual-8086 mode, IOPL, RF, VM, VIF and VIP keep their values. IF takes the popped value only when the privilege level is numerically less than or equal to IOPL.
- R4: A restore with privilege level greater than IOPL outside virtual-8086 mode raises no fault. IF stays unchanged while CF, PF, AF, ZF, SF, TF, DF, OF and NT still update.
- R5: With a 16-bit operand (op32_i=0), only bits 15:0 may change and bits 31:16 keep their values, so AC and ID change only with a 32-bit operand.
- R6: In virtual-8086 mode with IOPL equal to 3, the restore behaves as at privilege level 3 and raises no fault.
- R7: In virtual-8086 mode with IOPL below 3 and the extensions disabled, the restore faults and the status word is unchanged.
- R8: In virtual-8086 mode with IOPL below 3 and the extensions enabled, a 32-bit restore faults and the status word is unchanged.
- R9: In virtual-8086 mode with IOPL below 3, the extensions enabled and a 16-bit operand, the popped IF (bit 9) is written to VIF (bit 19) and IF is unchanged. The restore faults instead if the popped TF is 1, or if the popped IF is 1 while VIP is already set.
- R10: fault_o is high only in a cycle where valid_i is high, so it is a one-cycle pulse per strobe. Without valid_i the status word does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| valid_i | input | 1 | Restore strobe, one cycle per restore |
| popped_i | input | 32 | Flags value popped from the stack |
| cpl_i | input | 2 | Current privilege level |
| v86_i | input | 1 | Virtual-8086 mode active |
| op32_i | input | 1 | 1 = 32-bit operand, 0 = 16-bit operand |
| vext_en_i | input | 1 | Virtual-mode extensions enabled |
| status_o | output | 32 | Current status word |
| fault_o | output | 1 | General-protection fault, same cycle as valid_i |

## Verification
The fault decision is combinational, so fault_o is due in the same cycle as the strobe. The new status word appears one clock edge after the strobe. The bench drives each strobe just after a falling edge and samples fault_o shortly afterwards, before the rising edge. It then checks status_o after the following falling edge, once the single register stage has loaded. Because reset is released through a two-stage synchronizer, the bench waits several cycles after deasserting rst_n before it applies the first strobe.

// File: rtl/frm_pkg.sv
package frm_pkg;
  localparam int unsigned STAT_W = 32;

  localparam int unsigned B_CF   = 0;
  localparam int unsigned B_TF   = 8;
  localparam int unsigned B_IF   = 9;
  localparam int unsigned B_IOPL = 12;
  localparam int unsigned B_RF   = 16;
  localparam int unsigned B_VM   = 17;
  localparam int unsigned B_VIF  = 19;
  localparam int unsigned B_VIP  = 20;

  localparam logic [STAT_W-1:0] M_ARITH   = 32'h0000_4DD5;
  localparam logic [STAT_W-1:0] M_IF      = 32'h0000_0200;
  localparam logic [STAT_W-1:0] M_IOPL    = 32'h0000_3000;
  localparam logic [STAT_W-1:0] M_RF      = 32'h0001_0000;
  localparam logic [STAT_W-1:0] M_AC_ID   = 32'h0024_0000;
  localparam logic [STAT_W-1:0] M_LOW16   = 32'h0000_FFFF;
  localparam logic [STAT_W-1:0] M_DEFINED = 32'h003F_7FD5;
  localparam logic [STAT_W-1:0] RESET_VAL = 32'h0000_0002;

  localparam logic [STAT_W-1:0] M_RING0 = M_ARITH | M_IF | M_IOPL | M_RF | M_AC_ID;
  localparam logic [STAT_W-1:0] M_USER  = M_ARITH | M_AC_ID;
endpackage

// File: rtl/frm_rst_sync.sv
module frm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/frm_mask_gen.sv
module frm_mask_gen
  import frm_pkg::*;
(
  input  logic [STAT_W-1:0] cur_i,
  input  logic [STAT_W-1:0] popped_i,
  input  logic [1:0]        cpl_i,
  input  logic              v86_i,
  input  logic              op32_i,
  input  logic              vext_en_i,
  output logic [STAT_W-1:0] mask_o,
  output logic              vif_wr_o,
  output logic              fault_o
);
  logic [1:0] iopl;
  logic       cpl_ok;
  logic [STAT_W-1:0] raw_mask;

  assign iopl   = cur_i[B_IOPL +: 2];
  assign cpl_ok = (cpl_i <= iopl);

  always_comb begin
    raw_mask = '0;
    vif_wr_o = 1'b0;
    fault_o  = 1'b0;
    if (!v86_i) begin
      if (cpl_i == 2'd0) raw_mask = M_RING0;
      else               raw_mask = M_USER | (cpl_ok ? M_IF : '0);
    end else if (iopl == 2'd3) begin
      raw_mask = M_USER | M_IF;
    end else if (!vext_en_i || op32_i) begin
      fault_o = 1'b1;
    end else begin
      raw_mask = M_ARITH;
      vif_wr_o = 1'b1;
      fault_o  = popped_i[B_TF] | (popped_i[B_IF] & cur_i[B_VIP]);
    end
  end

  assign mask_o = op32_i ? raw_mask : (raw_mask & M_LOW16);
endmodule

// File: rtl/frm_merge.sv
module frm_merge
  import frm_pkg::*;
(
  input  logic [STAT_W-1:0] cur_i,
  input  logic [STAT_W-1:0] popped_i,
  input  logic [STAT_W-1:0] mask_i,
  input  logic              vif_wr_i,
  output logic [STAT_W-1:0] nxt_o
);
  logic [STAT_W-1:0] blend;

  always_comb begin
    blend = (cur_i & ~mask_i) | (popped_i & mask_i);
    if (vif_wr_i) blend[B_VIF] = popped_i[B_IF];
    nxt_o    = blend & M_DEFINED;
    nxt_o[1] = 1'b1;
  end
endmodule

// File: rtl/flag_restore_unit.sv
module flag_restore_unit
  import frm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        valid_i,
  input  logic [31:0] popped_i,
  input  logic [1:0]  cpl_i,
  input  logic        v86_i,
  input  logic        op32_i,
  input  logic        vext_en_i,
  output logic [31:0] status_o,
  output logic        fault_o
);
  logic              rst_sync_n;
  logic [STAT_W-1:0] status_q, status_d, merged, mask;
  logic              vif_wr, fault_raw, status_en;

  frm_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  frm_mask_gen u_mask (
    .cur_i(status_q), .popped_i(popped_i), .cpl_i(cpl_i), .v86_i(v86_i),
    .op32_i(op32_i), .vext_en_i(vext_en_i),
    .mask_o(mask), .vif_wr_o(vif_wr), .fault_o(fault_raw)
  );

  frm_merge u_merge (
    .cur_i(status_q), .popped_i(popped_i), .mask_i(mask),
    .vif_wr_i(vif_wr), .nxt_o(merged)
  );

  assign fault_o   = valid_i & fault_raw;
  assign status_en = valid_i & ~fault_raw;

  always_comb begin
    status_d = status_q;
    if (status_en) status_d = merged;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) status_q <= RESET_VAL;
    else             status_q <= status_d;
  end

  assign status_o = status_q;

  p_fixed_bits_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (status_q[1] == 1'b1) && ((status_q & ~(M_DEFINED | RESET_VAL)) == '0));
  p_vm_kept_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    valid_i |=> $stable(status_q[B_VM]) && $stable(status_q[B_VIP]));
  p_ring_nofault_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid_i && !v86_i) |-> !fault_o);
  p_v86_iopl3_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid_i && v86_i && status_q[B_IOPL +: 2] == 2'd3) |-> !fault_o);
  p_nofault_write_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fault_o |=> $stable(status_q));
  p_vext32_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid_i && v86_i && op32_i && status_q[B_IOPL +: 2] != 2'd3) |-> fault_o);
  p_tf_fault_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid_i && v86_i && vext_en_i && !op32_i && popped_i[B_TF]
     && status_q[B_IOPL +: 2] != 2'd3) |-> fault_o);
  p_fault_strobe_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fault_o |-> valid_i);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !valid_i |=> $stable(status_q));
endmodule

// File: tb/flag_restore_unit_test.sv
module flag_restore_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_i;
  logic [31:0] popped_i;
  logic [1:0]  cpl_i;
  logic        v86_i, op32_i, vext_en_i;
  logic [31:0] status_o;
  logic        fault_o;

  int checks = 0;
  int fails  = 0;
  logic [31:0] shadow;

  always #5 clk = ~clk;

  flag_restore_unit uut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .popped_i(popped_i),
    .cpl_i(cpl_i), .v86_i(v86_i), .op32_i(op32_i), .vext_en_i(vext_en_i),
    .status_o(status_o), .fault_o(fault_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One strobe: exp_fault/exp_status come from the requirements of each scenario.
  task automatic restore(input string req, input logic [31:0] pop, input logic [1:0] cpl,
                         input logic v86, input logic op32, input logic vext,
                         input logic exp_fault, input logic [31:0] exp_status);
    @(negedge clk);
    popped_i = pop; cpl_i = cpl; v86_i = v86; op32_i = op32; vext_en_i = vext;
    valid_i = 1'b1;
    #1 check({req, " fault"}, {31'd0, fault_o}, {31'd0, exp_fault});
    @(negedge clk);
    valid_i = 1'b0;
    #1 check({req, " status"}, status_o, exp_status);
    shadow = status_o;
  endtask

  task automatic t_reset;  // R1
    check("R1 reset", status_o, 32'h0000_0002);
    check("R1 fault idle", {31'd0, fault_o}, 32'd0);
  endtask

  task automatic t_ring0;  // R2: all defined bits but VM/VIP/VIF
    restore("R2 ring0 ones", 32'hFFFF_FFFF, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0025_7FD7);
  endtask

  task automatic t_user_iopl3;  // R3: IOPL=3, cpl 3; IF may change, IOPL/RF kept
    restore("R3 cpl3 zeros", 32'h0000_0000, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0001_3002);
  endtask

  task automatic t_insufficient;  // R4: IOPL=0, cpl 3, IF protected silently
    restore("R4 ring0 clear", 32'h0000_0000, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_0002);
    restore("R4 cpl3 ones", 32'hFFFF_FFFF, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0024_4DD7);
  endtask

  task automatic t_op16;  // R5: upper half kept with 16-bit operand
    restore("R5 op16 ring0", 32'h0000_0000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0024_0002);
    restore("R5 op32 clears AC/ID", 32'h0000_0000, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_0002);
  endtask

  task automatic t_v86_iopl3;  // R6
    restore("R6 set iopl3", 32'h0000_3000, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_3002);
    restore("R6 v86 iopl3", 32'h0000_0FD5, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_3FD7);
  endtask

  task automatic t_v86_fault;  // R7, R8
    restore("R7 clear iopl", 32'h0000_0000, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_0002);
    restore("R7 v86 no ext", 32'h0000_0FD5, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0000_0002);
    restore("R8 v86 ext op32", 32'h0000_0FD5, 2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_0002);
  endtask

  task automatic t_vext16;  // R9: IF -> VIF, IF kept; TF faults
    restore("R9 vif set", 32'h0000_0201, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0008_0003);
    restore("R9 vif clear", 32'h0000_0000, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0000_0002);
    restore("R9 tf faults", 32'h0000_0100, 2'd3, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0000_0002);
  endtask

  task automatic t_idle;  // R10: no strobe, no change, no fault
    @(negedge clk);
    popped_i = 32'hFFFF_FFFF; cpl_i = 2'd0; v86_i = 1'b1; op32_i = 1'b1; vext_en_i = 1'b0;
    valid_i = 1'b0;
    #1 check("R10 no fault w/o valid", {31'd0, fault_o}, 32'd0);
    @(negedge clk);
    #1 check("R10 hold", status_o, shadow);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; valid_i = 1'b0; popped_i = '0; cpl_i = '0;
    v86_i = 1'b0; op32_i = 1'b1; vext_en_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    shadow = 32'h0000_0002;
    t_reset();
    t_ring0();
    t_user_iopl3();
    t_insufficient();
    t_op16();
    t_v86_iopl3();
    t_v86_fault();
    t_vext16();
    t_idle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule